// File: doc/BRIEF.md
# Program Counter Load Unit

This block holds the program counter of a small 8-bit microcontroller core and decides, every clock, what the counter holds next. The counter is 13 bits wide. Software can see only its low byte, as a register. The five high bits are never written on their own. A separate 8-bit latch register, which lies outside this block and reaches it as an input, supplies them. Which latch bits are used depends on the kind of load.

Each cycle the unit picks one of four sources for the next value: the next sequential address, a write of ALU data to the low-byte register, a jump or call carrying an 11-bit literal from the opcode, or an address popped from the return stack. If no strobe is asserted, the counter holds its value. The counter output goes straight to instruction fetch. Instruction decode, the ALU, the stack storage and the program memory are all outside this block.

Top module: `pc_load_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter becomes 0 on that edge, whatever the strobes are.
- R2: When `inc_en` is the only strobe asserted, the counter becomes (current + 1) modulo 8192 on the next edge. A carry out of bit 7 propagates into bits 12:8, and 0x1FFF wraps to 0x0000.
- R3: When a low-byte write (`lo_wr_en`) is the highest-priority strobe, bits 7:0 of the counter take `lo_wr_data`. On the same edge, bits 12:8 take `latch_q[4:0]`.
- R4: When a jump or call (`jmp_en`) is the highest-priority strobe, bits 10:0 take `jmp_lit`, and bits 12:11 take `latch_q[4:3]`.
- R5: When a stack return (`ret_en`) is asserted, the counter takes `ret_pc` whole on the next edge. The latch plays no part in this load.
- R6: The priority among the strobes is: reset, then stack return, then jump/call, then low-byte write, then increment. Only the winning source affects the next value.
- R7: With no strobe asserted, the counter keeps its value.
- R8: Latch bits 7:5 never reach the counter. On a jump, latch bits 2:0 are ignored as well.
- R9: `pcl_q` always equals bits 7:0 of `pc_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | 1 | Sequential increment strobe |
| lo_wr_en | input | 1 | Write strobe for the low-byte register |
| lo_wr_data | input | 8 | ALU result written to the low byte |
| jmp_en | input | 1 | Jump or call strobe |
| jmp_lit | input | 11 | Address literal taken from the opcode |
| ret_en | input | 1 | Stack-return load strobe |
| ret_pc | input | 13 | Address popped from the return stack |
| latch_q | input | 8 | Contents of the high-address latch register |
| pc_q | output | 13 | Current program counter, sent to fetch |
| pcl_q | output | 8 | Software-visible low byte of the counter |

## Verification
The clocked properties assume that every strobe and data input is a known 0 or 1 at each rising edge. They also assume that reset is asserted at the first edge, so the counter never starts from an unknown value. The stimulus changes inputs only on falling edges and holds reset through the first edges. After that it sweeps the counter through its full range, every low-byte value, every jump literal and all sixteen strobe combinations. Latch values are chosen so that its unused upper bits are set during these sweeps.

// File: rtl/pc_load_pkg.sv
package pc_load_pkg;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOWR = 3'd2,
    SRC_JUMP = 3'd3,
    SRC_RET  = 3'd4
  } pc_src_e;

endpackage

// File: rtl/pc_src_arbiter.sv
module pc_src_arbiter
  import pc_load_pkg::*;
(
  input  logic    inc_en,
  input  logic    lo_wr_en,
  input  logic    jmp_en,
  input  logic    ret_en,
  output pc_src_e src
);

  // Fixed priority: return > jump/call > low-byte write > increment
  always_comb begin
    if (ret_en)        src = SRC_RET;
    else if (jmp_en)   src = SRC_JUMP;
    else if (lo_wr_en) src = SRC_LOWR;
    else if (inc_en)   src = SRC_INC;
    else               src = SRC_HOLD;
  end

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pc_load_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int LIT_W   = 11,
  parameter int LATCH_W = 8
) (
  input  pc_src_e             src,
  input  logic [PC_W-1:0]     pc_cur,
  input  logic [LO_W-1:0]     lo_data,
  input  logic [LIT_W-1:0]    lit,
  input  logic [PC_W-1:0]     ret_pc,
  input  logic [LATCH_W-1:0]  latch,
  output logic [PC_W-1:0]     pc_nxt
);

  localparam int HI_W  = PC_W - LO_W;   // high bits filled on a low-byte write
  localparam int JHI_W = PC_W - LIT_W;  // high bits filled on a jump/call

  logic [PC_W-1:0] seq_val;
  logic [PC_W-1:0] lowr_val;
  logic [PC_W-1:0] jump_val;

  assign seq_val  = pc_cur + PC_W'(1);
  assign lowr_val = {latch[HI_W-1:0], lo_data};
  assign jump_val = {latch[HI_W-1 -: JHI_W], lit};

  always_comb begin
    unique case (src)
      SRC_INC:  pc_nxt = seq_val;
      SRC_LOWR: pc_nxt = lowr_val;
      SRC_JUMP: pc_nxt = jump_val;
      SRC_RET:  pc_nxt = ret_pc;
      default:  pc_nxt = pc_cur;
    endcase
  end

endmodule

// File: rtl/pc_load_unit.sv
module pc_load_unit
  import pc_load_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int LIT_W   = 11,
  parameter int LATCH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_en,
  input  logic               lo_wr_en,
  input  logic [LO_W-1:0]    lo_wr_data,
  input  logic               jmp_en,
  input  logic [LIT_W-1:0]   jmp_lit,
  input  logic               ret_en,
  input  logic [PC_W-1:0]    ret_pc,
  input  logic [LATCH_W-1:0] latch_q,
  output logic [PC_W-1:0]    pc_q,
  output logic [LO_W-1:0]    pcl_q
);

  pc_src_e         src;
  logic [PC_W-1:0] pc_nxt;

  pc_src_arbiter arb_i (
    .inc_en   (inc_en),
    .lo_wr_en (lo_wr_en),
    .jmp_en   (jmp_en),
    .ret_en   (ret_en),
    .src      (src)
  );

  pc_next_mux #(
    .PC_W    (PC_W),
    .LO_W    (LO_W),
    .LIT_W   (LIT_W),
    .LATCH_W (LATCH_W)
  ) mux_i (
    .src     (src),
    .pc_cur  (pc_q),
    .lo_data (lo_wr_data),
    .lit     (jmp_lit),
    .ret_pc  (ret_pc),
    .latch   (latch_q),
    .pc_nxt  (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pcl_q = pc_q[LO_W-1:0];

endmodule

// File: rtl/pc_load_unit_chk.sv
module pc_load_unit_chk #(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int LIT_W   = 11,
  parameter int LATCH_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inc_en,
  input logic               lo_wr_en,
  input logic [LO_W-1:0]    lo_wr_data,
  input logic               jmp_en,
  input logic [LIT_W-1:0]   jmp_lit,
  input logic               ret_en,
  input logic [PC_W-1:0]    ret_pc,
  input logic [LATCH_W-1:0] latch_q,
  input logic [PC_W-1:0]    pc_q,
  input logic [LO_W-1:0]    pcl_q
);

  localparam int HI_W  = PC_W - LO_W;
  localparam int JHI_W = PC_W - LIT_W;

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !lo_wr_en && !jmp_en && !ret_en) |=> (pc_q == $past(pc_q) + PC_W'(1)));

  a_r3_low_write: assert property (@(posedge clk) disable iff (rst)
    (lo_wr_en && !jmp_en && !ret_en) |=>
      (pc_q[LO_W-1:0] == $past(lo_wr_data) &&
       pc_q[PC_W-1:LO_W] == $past(latch_q[HI_W-1:0])));

  a_r4_jump: assert property (@(posedge clk) disable iff (rst)
    (jmp_en && !ret_en) |=>
      (pc_q[LIT_W-1:0] == $past(jmp_lit) &&
       pc_q[PC_W-1:LIT_W] == $past(latch_q[HI_W-1 -: JHI_W])));

  a_r5_return: assert property (@(posedge clk) disable iff (rst)
    ret_en |=> (pc_q == $past(ret_pc)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc_en && !lo_wr_en && !jmp_en && !ret_en) |=> $stable(pc_q));

endmodule

bind pc_load_unit pc_load_unit_chk #(
  .PC_W    (PC_W),
  .LO_W    (LO_W),
  .LIT_W   (LIT_W),
  .LATCH_W (LATCH_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .inc_en     (inc_en),
  .lo_wr_en   (lo_wr_en),
  .lo_wr_data (lo_wr_data),
  .jmp_en     (jmp_en),
  .jmp_lit    (jmp_lit),
  .ret_en     (ret_en),
  .ret_pc     (ret_pc),
  .latch_q    (latch_q),
  .pc_q       (pc_q),
  .pcl_q      (pcl_q)
);

// File: tb/pc_load_unit_tb_top.sv
`timescale 1ns/1ps
module pc_load_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc_en = 1'b0;
  logic        lo_wr_en = 1'b0;
  logic [7:0]  lo_wr_data = '0;
  logic        jmp_en = 1'b0;
  logic [10:0] jmp_lit = '0;
  logic        ret_en = 1'b0;
  logic [12:0] ret_pc = '0;
  logic [7:0]  latch_q = '0;
  logic [12:0] pc_q;
  logic [7:0]  pcl_q;

  int tests = 0;
  int failed = 0;
  logic done = 1'b0;
  logic [12:0] exp_pc = '0;

  always #4 clk = ~clk;

  pc_load_unit dut_i (
    .clk (clk), .rst (rst), .inc_en (inc_en), .lo_wr_en (lo_wr_en),
    .lo_wr_data (lo_wr_data), .jmp_en (jmp_en), .jmp_lit (jmp_lit),
    .ret_en (ret_en), .ret_pc (ret_pc), .latch_q (latch_q),
    .pc_q (pc_q), .pcl_q (pcl_q)
  );

  // Model of the next counter value, written from the requirements
  function automatic logic [12:0] model_next(logic [12:0] cur);
    if (rst)           return 13'd0;                          // R1
    else if (ret_en)   return ret_pc;                         // R5, R6
    else if (jmp_en)   return {latch_q[4:3], jmp_lit};        // R4, R8
    else if (lo_wr_en) return {latch_q[4:0], lo_wr_data};     // R3, R8
    else if (inc_en)   return cur + 13'd1;                    // R2
    else               return cur;                            // R7
  endfunction

  task automatic check(input string req);
    tests++;
    if (pc_q !== exp_pc) begin
      failed++;
      $display("FAIL %s pc_q actual=%h expected=%h", req, pc_q, exp_pc);
    end
    tests++;
    if (pcl_q !== exp_pc[7:0]) begin
      failed++;
      $display("FAIL R9 (%s) pcl_q actual=%h expected=%h", req, pcl_q, exp_pc[7:0]);
    end
  endtask

  // Inputs were set after a falling edge; clock one edge, check at the next falling edge
  task automatic step(input string req);
    @(posedge clk);
    exp_pc = model_next(exp_pc);
    @(negedge clk);
    check(req);
  endtask

  task automatic idle_strobes();
    rst = 1'b0; inc_en = 1'b0; lo_wr_en = 1'b0; jmp_en = 1'b0; ret_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b1; step("R1 reset");
    idle_strobes();

    // R2: full sweep through every address and the wrap back to zero
    inc_en = 1'b1;
    for (int k = 0; k < 8200; k++) step("R2 increment");
    idle_strobes();

    // R3/R8: every low-byte value, latch upper bits varied
    lo_wr_en = 1'b1;
    for (int k = 0; k < 256; k++) begin
      lo_wr_data = 8'(k) ^ 8'hA5;
      latch_q    = 8'(k * 7);
      step("R3 low write");
    end
    idle_strobes();

    // R2: carry from low byte into high bits after a low write
    lo_wr_en = 1'b1; lo_wr_data = 8'hFF; latch_q = 8'hE4; step("R3 low write");
    lo_wr_en = 1'b0; inc_en = 1'b1; latch_q = 8'h00; step("R2 carry into high bits");
    idle_strobes();

    // R4/R8: every jump literal, all latch values
    jmp_en = 1'b1;
    for (int k = 0; k < 2048; k++) begin
      jmp_lit = 11'(k);
      latch_q = 8'(k * 13 + 5);
      step("R4 jump");
    end
    idle_strobes();

    // R5: stack returns, latch ignored
    ret_en = 1'b1;
    for (int k = 0; k < 512; k++) begin
      ret_pc  = 13'(k * 37 + 11);
      latch_q = 8'(~k);
      step("R5 return");
    end
    idle_strobes();

    // R7: hold with data inputs wiggling
    for (int k = 0; k < 16; k++) begin
      lo_wr_data = 8'(k * 3); jmp_lit = 11'(k * 99); latch_q = 8'(k * 17); ret_pc = 13'(k);
      step("R7 hold");
    end

    // R6: all strobe combinations from a known nonzero state
    for (int m = 0; m < 16; m++) begin
      idle_strobes();
      ret_en = 1'b1; ret_pc = 13'h0ABC; step("R5 return");
      ret_en = m[3]; jmp_en = m[2]; lo_wr_en = m[1]; inc_en = m[0];
      ret_pc = 13'h1357; jmp_lit = 11'h2C6; lo_wr_data = 8'h5A; latch_q = 8'hF5;
      step("R6 priority");
    end
    idle_strobes();

    // R1: reset wins over all strobes
    ret_en = 1'b1; jmp_en = 1'b1; lo_wr_en = 1'b1; inc_en = 1'b1; ret_pc = 13'h1FFF;
    step("R5 return");
    rst = 1'b1; step("R1 reset over strobes");
    idle_strobes();
    step("R7 hold after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule